// File: doc/BRIEF.md
# Configuration Capability Chain Walker

The walker traverses the chain of capability headers that a configuration function may expose. A single `start` pulse begins a walk. The walker first reads the status half of the dword at byte offset 0x04 and looks at the capability-present flag. If the flag is set, it reads the root pointer from the dword at offset 0x34 and then fetches one header dword after another. Each fetched header goes out on a valid/ready entry stream as three fields: the header's byte offset, its ID and its upper 16 bits. Configuration reads use a simple request/acknowledge port. The request and its address stay steady until the acknowledge arrives, and read data is taken in the cycle in which the acknowledge is high.

A walk can end in four ways: the chain ends with a zero pointer; a pointer is malformed (below 64 or not dword aligned), which raises `warn`; 48 entries have been delivered and the chain still continues, which also raises `warn`; or, when search is enabled, an entry's ID equals `search_id`, which raises `match` and reports that entry's offset. One example of a search target is the vendor-specific ID 0x09. A one-cycle `done` pulse marks the end of every walk. `warn`, `match` and `match_offset` keep their values until the next accepted `start`.

States are `S_IDLE`, `S_STATUS`, `S_ROOT`, `S_HDR`, `S_EMIT` and `S_FINISH`. The transitions are:
- `S_IDLE` to `S_STATUS` on `start`.
- `S_STATUS` to `S_ROOT` on acknowledge when the capability flag is set, or to `S_FINISH` on acknowledge when the flag is clear.
- `S_ROOT` to `S_FINISH` on acknowledge when the root pointer is null or malformed, otherwise to `S_HDR`.
- `S_HDR` to `S_EMIT` on acknowledge.
- `S_EMIT` to `S_FINISH` on acceptance when any of these holds: a search hit, a null next pointer, a malformed next pointer, or the step limit is reached. Otherwise `S_EMIT` returns to `S_HDR`.
- `S_FINISH` to `S_IDLE` unconditionally.

Top module: `cap_walker`

## Requirements
- R1: After reset the walker is idle: `rd_req`, `ent_valid`, `done`, `busy`, `warn` and `match` are all 0.
- R2: The first read of a walk targets byte address 0x04. If bit 20 of that dword (bit 4 of the status half) is 0, no further read is made, no entry is produced, `done` pulses and `warn` stays 0.
- R3: When that bit is 1, the second read targets address 0x34. The root pointer is that dword's bits 7:0 with bits 1:0 forced to 0, and it becomes the address of the next read.
- R4: Each header read at address A yields one entry with `ent_offset`=A, `ent_id`=bits 7:0 and `ent_priv`=bits 31:16. Bits 15:8 are the next pointer, and the walker reads it next when it is valid.
- R5: A next pointer (or root pointer) of 0 ends the walk with `warn`=0.
- R6: A root or next pointer that is non-zero and either below 64 or has bits 1:0 not equal to 00 ends the walk with `warn`=1. No read is made at that pointer.
- R7: `ent_valid` stays high and the entry fields stay unchanged until `ent_ready` is seen. No header read is issued while an entry is waiting.
- R8: `done` is high for exactly one cycle per walk. When entries were produced, it is high in the cycle after the last entry is accepted.
- R9: When the 48th entry is accepted and its next pointer is still valid, the walk ends with `warn`=1 after exactly 48 entries.
- R10: With `search_en`=1, the first entry whose ID equals `search_id` sets `match`=1 and `match_offset` to that entry's offset, and the walk ends after that entry. With `search_en`=0, IDs are ignored and `match` stays 0.
- R11: `rd_req` stays high with an unchanged `rd_addr` until `rd_ack` is seen.
- R12: A `start` pulse during a walk is ignored: the walk in progress produces the same entries and a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| search_en | input | 1 | Enable ID search, latched at start |
| search_id | input | 8 | ID to search for, latched at start |
| rd_req | output | 1 | Configuration read request |
| rd_addr | output | ADDR_W | Byte address of the requested dword |
| rd_ack | input | 1 | Read acknowledge, data valid |
| rd_data | input | 32 | Read data |
| ent_valid | output | 1 | Entry available |
| ent_ready | input | 1 | Entry accepted by the consumer |
| ent_offset | output | ADDR_W | Byte offset of the header |
| ent_id | output | 8 | Capability ID |
| ent_priv | output | 16 | Upper 16 header bits |
| done | output | 1 | One-cycle end-of-walk pulse |
| busy | output | 1 | Walk in progress |
| warn | output | 1 | Walk ended on a malformed pointer or on the step limit |
| match | output | 1 | Search hit found |
| match_offset | output | ADDR_W | Offset of the search hit |

## Verification
An acknowledge sampled at a clock edge moves the state machine at that same edge. The read address and entry that follow are therefore visible one edge later, and the bench samples them at the falling edge after that. An entry is accepted at the rising edge where `ent_valid` and `ent_ready` are both high, and `done` is high for the whole following cycle. The bench notes the cycle of each acceptance and of each `done` and compares them, so the one-cycle spacing is checked directly. The bench's read responder and entry sink change their outputs only at falling edges, and every value is compared half a cycle away from the rising edge that produced it.

// File: rtl/cw_pkg.sv
package cw_pkg;

    localparam int CW_DW          = 32;
    localparam int CW_STATUS_OFS  = 8'h04;
    localparam int CW_ROOT_OFS    = 8'h34;
    localparam int CW_CAP_FLAG    = 20;     // bit 4 of the upper status half
    localparam int CW_ID_VENDOR   = 8'h09;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STATUS,
        S_ROOT,
        S_HDR,
        S_EMIT,
        S_FINISH
    } walk_state_t;

endpackage

// File: rtl/cw_ptr_check.sv
module cw_ptr_check #(
    parameter int ADDR_W  = 8,
    parameter int MIN_PTR = 64
) (
    input  logic [ADDR_W-1:0] ptr,
    output logic              is_null,
    output logic              is_bad
);
    localparam logic [ADDR_W-1:0] FLOOR = ADDR_W'(MIN_PTR);

    always_comb begin
        is_null = (ptr == '0);
        is_bad  = !is_null && ((ptr < FLOOR) || (ptr[1:0] != 2'b00));
    end
endmodule

// File: rtl/cw_step_ctr.sv
module cw_step_ctr #(
    parameter int LIMIT = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_slot
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= '0;
        else if (clr)
            count_q <= '0;
        else if (inc && count_q != CW'(LIMIT))
            count_q <= count_q + 1'b1;
    end

    // true while the entry being accepted is the LIMIT-th of the walk
    assign last_slot = (count_q == CW'(LIMIT - 1));
endmodule

// File: rtl/cap_walker.sv
module cap_walker
    import cw_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MAX_STEPS = 48,
    parameter int MIN_PTR   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              search_en,
    input  logic [7:0]        search_id,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [CW_DW-1:0]  rd_data,
    output logic              ent_valid,
    input  logic              ent_ready,
    output logic [ADDR_W-1:0] ent_offset,
    output logic [7:0]        ent_id,
    output logic [15:0]       ent_priv,
    output logic              done,
    output logic              busy,
    output logic              warn,
    output logic              match,
    output logic [ADDR_W-1:0] match_offset
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(CW_STATUS_OFS);
    localparam logic [ADDR_W-1:0] A_ROOT   = ADDR_W'(CW_ROOT_OFS);

    walk_state_t state_q, state_d;

    logic [ADDR_W-1:0] ptr_q, next_q, match_off_q;
    logic [7:0]        id_q, srch_id_q;
    logic [15:0]       priv_q;
    logic              srch_en_q, warn_q, match_q;

    logic [ADDR_W-1:0] root_ptr, chk_ptr;
    logic              chk_null, chk_bad, last_slot;
    logic              accept, hit, walk_go;

    assign root_ptr = ADDR_W'({rd_data[7:2], 2'b00});
    assign chk_ptr  = (state_q == S_ROOT) ? root_ptr : next_q;
    assign accept   = (state_q == S_EMIT) && ent_ready;
    assign hit      = srch_en_q && (id_q == srch_id_q);
    assign walk_go  = (state_q == S_IDLE) && start;

    cw_ptr_check #(
        .ADDR_W (ADDR_W),
        .MIN_PTR(MIN_PTR)
    ) u_ptr_check (
        .ptr    (chk_ptr),
        .is_null(chk_null),
        .is_bad (chk_bad)
    );

    cw_step_ctr #(
        .LIMIT(MAX_STEPS)
    ) u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (walk_go),
        .inc      (accept),
        .last_slot(last_slot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = S_STATUS;
            S_STATUS: if (rd_ack) state_d = rd_data[CW_CAP_FLAG] ? S_ROOT : S_FINISH;
            S_ROOT:   if (rd_ack) state_d = (chk_null || chk_bad) ? S_FINISH : S_HDR;
            S_HDR:    if (rd_ack) state_d = S_EMIT;
            S_EMIT: begin
                if (ent_ready) begin
                    if (hit || chk_null || chk_bad || last_slot)
                        state_d = S_FINISH;
                    else
                        state_d = S_HDR;
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // walk data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            next_q      <= '0;
            id_q        <= '0;
            priv_q      <= '0;
            srch_en_q   <= 1'b0;
            srch_id_q   <= '0;
            warn_q      <= 1'b0;
            match_q     <= 1'b0;
            match_off_q <= '0;
        end else begin
            if (walk_go) begin
                srch_en_q   <= search_en;
                srch_id_q   <= search_id;
                warn_q      <= 1'b0;
                match_q     <= 1'b0;
                match_off_q <= '0;
            end
            if (state_q == S_ROOT && rd_ack) begin
                ptr_q <= root_ptr;
                if (chk_bad) warn_q <= 1'b1;
            end
            if (state_q == S_HDR && rd_ack) begin
                id_q   <= rd_data[7:0];
                next_q <= ADDR_W'(rd_data[15:8]);
                priv_q <= rd_data[31:16];
            end
            if (accept) begin
                if (hit) begin
                    match_q     <= 1'b1;
                    match_off_q <= ptr_q;
                end else if (chk_null) begin
                    warn_q <= warn_q;
                end else if (chk_bad || last_slot) begin
                    warn_q <= 1'b1;
                end else begin
                    ptr_q <= next_q;
                end
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        rd_req    = 1'b0;
        rd_addr   = '0;
        ent_valid = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            S_IDLE:   busy = 1'b0;
            S_STATUS: begin rd_req = 1'b1; rd_addr = A_STATUS; end
            S_ROOT:   begin rd_req = 1'b1; rd_addr = A_ROOT;   end
            S_HDR:    begin rd_req = 1'b1; rd_addr = ptr_q;    end
            S_EMIT:   ent_valid = 1'b1;
            S_FINISH: done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign ent_offset   = ptr_q;
    assign ent_id       = id_q;
    assign ent_priv     = priv_q;
    assign warn         = warn_q;
    assign match        = match_q;
    assign match_offset = match_off_q;

endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
    parameter int ADDR_W  = 8,
    parameter int MIN_PTR = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              rd_ack,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              ent_valid,
    input logic              ent_ready,
    input logic [ADDR_W-1:0] ent_offset,
    input logic [7:0]        ent_id,
    input logic [15:0]       ent_priv,
    input logic              done,
    input logic              warn,
    input logic              match
);
    p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    p_entry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_offset)
                                       && $stable(ent_id) && $stable(ent_priv)));

    p_no_read_while_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> !rd_req);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_entry_offset_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> (ent_offset >= ADDR_W'(MIN_PTR) && ent_offset[1:0] == 2'b00));

    p_match_excludes_warn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> !warn);
endmodule

bind cap_walker cw_checker #(
    .ADDR_W (ADDR_W),
    .MIN_PTR(MIN_PTR)
) u_cw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_ack    (rd_ack),
    .rd_addr   (rd_addr),
    .ent_valid (ent_valid),
    .ent_ready (ent_ready),
    .ent_offset(ent_offset),
    .ent_id    (ent_id),
    .ent_priv  (ent_priv),
    .done      (done),
    .warn      (warn),
    .match     (match)
);

// File: tb/tb_cap_walker.sv
module tb_cap_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        search_en = 1'b0;
    logic [7:0]  search_id = 8'h00;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = 32'h0;
    logic        ent_valid;
    logic        ent_ready = 1'b0;
    logic [7:0]  ent_offset;
    logic [7:0]  ent_id;
    logic [15:0] ent_priv;
    logic        done;
    logic        busy;
    logic        warn;
    logic        match;
    logic [7:0]  match_offset;

    always #2 clk = ~clk;   // 250 MHz

    cap_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .search_en(search_en), .search_id(search_id),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .ent_valid(ent_valid), .ent_ready(ent_ready),
        .ent_offset(ent_offset), .ent_id(ent_id), .ent_priv(ent_priv),
        .done(done), .busy(busy), .warn(warn), .match(match),
        .match_offset(match_offset)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [31:0] cfg [64];
    int lat = 0;
    int rdy_mode = 0;

    logic [7:0]  got_off [64];
    logic [7:0]  got_id  [64];
    logic [15:0] got_prv [64];
    int n_got = 0;
    logic [7:0] rd_log [64];
    int n_rd = 0;
    int n_done = 0;
    int acc_cyc = -1;
    int done_cyc = -1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // read responder, entry sink and event recorder, all at falling edges
    initial begin
        int wcnt;
        logic pend_rd, pend_ent;
        logic [7:0] pend_addr, s_off, s_id;
        logic [15:0] s_prv;
        wcnt = 0; pend_rd = 0; pend_ent = 0;
        pend_addr = 0; s_off = 0; s_id = 0; s_prv = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pend_rd) begin
                    chk("R11", "request held", 32'(rd_req), 32'h1);
                    chk("R11", "address held", 32'(rd_addr), 32'(pend_addr));
                end
                if (pend_ent) begin
                    chk("R7", "valid held", 32'(ent_valid), 32'h1);
                    chk("R7", "fields held", {8'h0, ent_offset, ent_id, 8'h0} ^ 32'(ent_priv),
                        {8'h0, s_off, s_id, 8'h0} ^ 32'(s_prv));
                end
            end
            if (rd_ack) begin
                rd_ack = 1'b0;
                wcnt = 0;
            end else if (rd_req) begin
                if (wcnt >= lat) begin
                    rd_data = cfg[rd_addr[7:2]];
                    rd_ack = 1'b1;
                    if (n_rd < 64) rd_log[n_rd] = rd_addr;
                    n_rd++;
                end else begin
                    wcnt++;
                end
            end
            pend_rd = rd_req && !rd_ack;
            pend_addr = rd_addr;
            ent_ready = (rdy_mode == 0) ? 1'b1 : ~ent_ready;
            if (ent_valid && ent_ready) begin
                if (n_got < 64) begin
                    got_off[n_got] = ent_offset;
                    got_id[n_got]  = ent_id;
                    got_prv[n_got] = ent_priv;
                end
                n_got++;
                acc_cyc = cyc;
            end
            pend_ent = ent_valid && !ent_ready;
            s_off = ent_offset; s_id = ent_id; s_prv = ent_priv;
            if (done) begin
                n_done++;
                done_cyc = cyc;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic clear_cfg();
        for (int i = 0; i < 64; i++) cfg[i] = 32'h0;
    endtask

    task automatic put_cap(input logic [7:0] off, input logic [7:0] id,
                           input logic [7:0] nxt, input logic [15:0] prv);
        cfg[off[7:2]] = {prv, nxt, id};
    endtask

    task automatic run(input logic s_en, input logic [7:0] s_id,
                       input int l, input int rm, input bit restart);
        int t;
        lat = l; rdy_mode = rm;
        n_got = 0; n_rd = 0; n_done = 0; acc_cyc = -1; done_cyc = -1;
        @(negedge clk);
        search_en = s_en; search_id = s_id; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (n_done == 0 && t < 3000) begin
            @(negedge clk);
            t++;
            if (restart && t == 6) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        if (n_done == 0) chk("R8", "walk finished", 32'h0, 32'h1);
        repeat (4) @(negedge clk);
        chk("R8", "single done", 32'(n_done), 32'h1);
        chk("R1", "idle after walk", {30'h0, busy, ent_valid}, 32'h0);
    endtask

    task automatic basic_chain();
        clear_cfg();
        cfg[1]  = 32'h0010_0000;
        cfg[13] = 32'hAA55_0043;
        put_cap(8'h40, 8'h05, 8'h50, 16'h1234);
        put_cap(8'h50, 8'h11, 8'h7C, 16'hBEEF);
        put_cap(8'h7C, 8'h10, 8'h00, 16'h0A0B);
    endtask

    task automatic check_basic(input string tag);
        chk("R4", {tag, " entries"}, 32'(n_got), 32'd3);
        chk("R3", {tag, " root offset"}, 32'(got_off[0]), 32'h40);
        chk("R4", {tag, " id0"}, 32'(got_id[0]), 32'h05);
        chk("R4", {tag, " priv0"}, 32'(got_prv[0]), 32'h1234);
        chk("R4", {tag, " off1"}, 32'(got_off[1]), 32'h50);
        chk("R4", {tag, " priv1"}, 32'(got_prv[1]), 32'hBEEF);
        chk("R4", {tag, " off2"}, 32'(got_off[2]), 32'h7C);
        chk("R4", {tag, " id2"}, 32'(got_id[2]), 32'h10);
        chk("R5", {tag, " warn"}, 32'(warn), 32'h0);
        chk("R10", {tag, " match"}, 32'(match), 32'h0);
        chk("R8", {tag, " done timing"}, 32'(done_cyc), 32'(acc_cyc + 1));
    endtask

    task automatic t_reset();
        chk("R1", "reset outputs", {26'h0, rd_req, ent_valid, done, busy, warn, match}, 32'h0);
    endtask

    task automatic t_basic();
        basic_chain();
        run(1'b0, 8'h00, 0, 0, 1'b0);
        check_basic("basic");
        chk("R2", "read count", 32'(n_rd), 32'd5);
        chk("R2", "first read addr", 32'(rd_log[0]), 32'h04);
        chk("R3", "second read addr", 32'(rd_log[1]), 32'h34);
        chk("R3", "third read addr", 32'(rd_log[2]), 32'h40);
        chk("R4", "fifth read addr", 32'(rd_log[4]), 32'h7C);
    endtask

    task automatic t_stall();
        basic_chain();
        run(1'b0, 8'h00, 3, 1, 1'b0);
        check_basic("stall");
    endtask

    task automatic t_no_list();
        basic_chain();
        cfg[1] = 32'hFFEF_FFFF;
        run(1'b0, 8'h00, 0, 0, 1'b0);
        chk("R2", "no-list entries", 32'(n_got), 32'd0);
        chk("R2", "no-list reads", 32'(n_rd), 32'd1);
        chk("R2", "no-list warn", 32'(warn), 32'h0);
    endtask

    task automatic t_root_null();
        clear_cfg();
        cfg[1]  = 32'h0010_0000;
        cfg[13] = 32'h0000_0003;
        put_cap(8'h40, 8'h05, 8'h00, 16'h1111);
        run(1'b0, 8'h00, 0, 0, 1'b0);
        chk("R5", "null root entries", 32'(n_got), 32'd0);
        chk("R5", "null root reads", 32'(n_rd), 32'd2);
        chk("R5", "null root warn", 32'(warn), 32'h0);
    endtask

    task automatic t_root_bad();
        clear_cfg();
        cfg[1]  = 32'h0010_0000;
        cfg[13] = 32'h0000_0020;
        run(1'b0, 8'h00, 0, 0, 1'b0);
        chk("R6", "bad root entries", 32'(n_got), 32'd0);
        chk("R6", "bad root reads", 32'(n_rd), 32'd2);
        chk("R6", "bad root warn", 32'(warn), 32'h1);
    endtask

    task automatic t_bad_next(input logic [7:0] nxt, input string tag);
        clear_cfg();
        cfg[1]  = 32'h0010_0000;
        cfg[13] = 32'h0000_0040;
        put_cap(8'h40, 8'h03, nxt, 16'h2222);
        put_cap(8'h3C, 8'h04, 8'h00, 16'h0);
        put_cap(8'h40 + 8'h04, 8'h04, 8'h00, 16'h0);
        run(1'b0, 8'h00, 0, 0, 1'b0);
        chk("R6", {tag, " entries"}, 32'(n_got), 32'd1);
        chk("R6", {tag, " reads"}, 32'(n_rd), 32'd3);
        chk("R6", {tag, " warn"}, 32'(warn), 32'h1);
    endtask

    task automatic t_loop();
        bit all_ok;
        clear_cfg();
        cfg[1]  = 32'h0010_0000;
        cfg[13] = 32'h0000_0040;
        put_cap(8'h40, 8'h07, 8'h40, 16'h7777);
        run(1'b0, 8'h00, 0, 0, 1'b0);
        chk("R9", "loop entries", 32'(n_got), 32'd48);
        chk("R9", "loop warn", 32'(warn), 32'h1);
        all_ok = 1;
        for (int i = 0; i < 48; i++) if (got_off[i] != 8'h40) all_ok = 0;
        chk("R9", "loop offsets", 32'(all_ok), 32'h1);
    endtask

    task automatic search_chain();
        clear_cfg();
        cfg[1]  = 32'h0010_0000;
        cfg[13] = 32'h0000_0040;
        put_cap(8'h40, 8'h01, 8'h48, 16'h0101);
        put_cap(8'h48, 8'h09, 8'h60, 16'h0909);
        put_cap(8'h60, 8'h09, 8'h00, 16'h0A0A);
    endtask

    task automatic t_search_hit();
        search_chain();
        run(1'b1, 8'h09, 0, 0, 1'b0);
        chk("R10", "hit entries", 32'(n_got), 32'd2);
        chk("R10", "hit flag", 32'(match), 32'h1);
        chk("R10", "hit offset", 32'(match_offset), 32'h48);
        chk("R10", "hit warn", 32'(warn), 32'h0);
    endtask

    task automatic t_search_miss();
        search_chain();
        run(1'b1, 8'h22, 0, 0, 1'b0);
        chk("R10", "miss entries", 32'(n_got), 32'd3);
        chk("R10", "miss flag", 32'(match), 32'h0);
        search_chain();
        run(1'b0, 8'h09, 0, 0, 1'b0);
        chk("R10", "search off entries", 32'(n_got), 32'd3);
        chk("R10", "search off flag", 32'(match), 32'h0);
    endtask

    task automatic t_restart();
        basic_chain();
        run(1'b0, 8'h00, 1, 0, 1'b1);
        check_basic("restart R12");
        chk("R12", "restart reads", 32'(n_rd), 32'd5);
    endtask

    initial begin
        clear_cfg();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_stall();
        t_no_list();
        t_root_null();
        t_root_bad();
        t_bad_next(8'h3C, "low next");
        t_bad_next(8'h46, "unaligned next");
        t_loop();
        t_search_hit();
        t_search_miss();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule